// File: doc/BRIEF.md
# Character-Cell On-Screen Display Generator

This block lays a grid of text characters over a video raster. The raster is timed by external horizontal and vertical sync inputs, and the block draws one pixel per clock. Two counters follow the sync inputs. A start line and a start pixel place the grid on the screen. For each pixel inside the grid, the block reads the cell word from an internal video RAM and fetches the glyph rows from a computed character table. It then decides whether the pixel shows the foreground, a fringe border, the background or nothing.

Color is chosen per cell. A 3-bit index in the cell word selects either the shared row attribute pair or one of seven palette entries. When the foreground and background colors are equal, the background is not drawn. The glyph can be shown at normal size, at double size, or stretched in one direction only. A one-cycle interrupt marks the first pixel of every character row.

Top module: `osd_top`

## Requirements
- R1: While reset is held and afterwards until a sync edge places the grid, `osdRgb` is 0, and `osdOverlay` and `rowIrq` are low.
- R2: When `syncPol` is 1 both syncs are active high; when it is 0 both are active low. A sync edge is a clock on which the input is active after having been inactive on the previous clock.
- R3: A horizontal edge sets the pixel count to 0, and the count then rises by one per clock. A vertical edge makes the next horizontal edge start line 0. The outputs for pixel p of a line appear one clock after the pixel count equals p.
- R4: The grid is 10 rows by 24 columns. It starts at line `vStart` and pixel `hStart`. The cell at (row, col) is stored in the video RAM at address row*24+col, and it is written through `vramWe`/`vramAddr`/`vramWdata`.
- R5: A cell word carries the glyph code {word[11], word[7:0]} (512 glyphs) and the color index word[10:8].
- R6: Each glyph is 14 pixels wide by 18 lines tall. Glyph pixel (x, y) of code c is lit when (x + y + c) mod 5 = 0.
- R7: Color index 0 takes the foreground from `rowFg`. Index k from 1 to 7 takes the foreground from palette k-1, which is `paletteFlat[6(k-1)+5 : 6(k-1)]`. The background is always `rowBg`. Every color is 6 bits, two each for red, green and blue.
- R8: An unlit pixel that is not a fringe pixel is transparent when the foreground and background are equal. A transparent pixel has `osdOverlay` low and `osdRgb` 0. Otherwise the pixel shows the background with `osdOverlay` high.
- R9: `sizeMode` 00 is normal size, 01 doubles both directions, 10 doubles the width only and 11 doubles the height only. Doubling repeats each glyph pixel or glyph line twice.
- R10: With `fringeEn` high, an unlit pixel whose left, right, upper or lower neighbour in the same glyph is lit shows `fringeColor`. Positions outside the 14x18 glyph count as unlit.
- R11: `rowIrq` is high for exactly the output clock of the first pixel on the first screen line of every character row.
- R12: Pixels outside the grid have `osdOverlay` low and `osdRgb` 0. A lit pixel shows its foreground with `osdOverlay` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hsyncIn | input | 1 | Horizontal sync |
| vsyncIn | input | 1 | Vertical sync |
| syncPol | input | 1 | Active level shared by both syncs |
| vStart | input | 8 | First grid line, counted from the top of the field |
| hStart | input | 8 | First grid pixel, counted from the left edge |
| sizeMode | input | 2 | Character size selection |
| fringeEn | input | 1 | Enables the fringe border |
| fringeColor | input | 6 | Fringe color |
| rowFg | input | 6 | Row attribute foreground |
| rowBg | input | 6 | Row attribute background |
| paletteFlat | input | 42 | Seven 6-bit palette entries, entry 0 in the low bits |
| vramWe | input | 1 | Video RAM write strobe |
| vramAddr | input | 8 | Video RAM write address |
| vramWdata | input | 12 | Video RAM write word |
| osdRgb | output | 6 | Pixel color |
| osdOverlay | output | 1 | High where the display replaces the video |
| rowIrq | output | 1 | Start-of-character-row interrupt |

## Verification
The row interrupt and the fringe decision can fall on the same pixel. This happens when the first glyph pixel of a row is unlit but its right neighbour is lit. The bench sets cell 0 to code 4 with the fringe enabled. At the first pixel of the row, the scoreboard then expects the interrupt to be high and the fringe color to be shown in that same output clock. A dropped or delayed interrupt would be reported, and so would a fringe decision that waits for the interrupt cycle to end.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int GLYPH_W = 14;
  localparam int GLYPH_H = 18;
  localparam int GLYPH_MOD = 5;
  localparam int COL_W = 5;
  localparam int ROW_W = 4;
  localparam int GX_W = 4;
  localparam int GY_W = 5;
  localparam int WORD_W = 12;
  localparam int CODE_W = 9;
  localparam int COLOR_W = 6;
  localparam int NPAL = 7;

  // strobes and position handed from control to datapath
  typedef struct packed {
    logic             inWin;
    logic             rowStart;
    logic [COL_W-1:0] cellCol;
    logic [ROW_W-1:0] cellRow;
    logic [GX_W-1:0]  glyphX;
    logic [GY_W-1:0]  glyphY;
  } osd_pos_t;

  // computed character table: pixel lit when (x+y+code) mod 5 == 0
  function automatic logic glyph_bit(input logic [CODE_W-1:0] code, input int x, input int y);
    if (x < 0 || x >= GLYPH_W || y < 0 || y >= GLYPH_H) return 1'b0;
    return ((x + y + int'(code)) % GLYPH_MOD) == 0;
  endfunction
endpackage

// File: rtl/osd_ctrl.sv
module osd_ctrl
  import osd_pkg::*;
#(
  parameter int ROWS = 10,
  parameter int COLS = 24,
  parameter int HCNT_W = 11,
  parameter int VCNT_W = 10,
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  logic             syncPol,
  input  logic [POS_W-1:0] vStart,
  input  logic [POS_W-1:0] hStart,
  input  logic [1:0]       sizeMode,
  output osd_pos_t         pos
);
  localparam logic [HCNT_W-1:0] SPAN_X = HCNT_W'(COLS * GLYPH_W);
  localparam logic [VCNT_W-1:0] SPAN_Y = VCNT_W'(ROWS * GLYPH_H);
  localparam logic [HCNT_W-1:0] GW = HCNT_W'(GLYPH_W);
  localparam logic [VCNT_W-1:0] GH = VCNT_W'(GLYPH_H);

  logic hsAct, vsAct, hsPrev, vsPrev, hsEdge, vsEdge;
  logic dblW, dblH;
  logic [HCNT_W-1:0] hCnt, dx, gxt;
  logic [VCNT_W-1:0] vCnt, dy, gyt;

  assign hsAct  = syncPol ? hsyncIn : ~hsyncIn;
  assign vsAct  = syncPol ? vsyncIn : ~vsyncIn;
  assign hsEdge = hsAct & ~hsPrev;
  assign vsEdge = vsAct & ~vsPrev;
  assign dblW   = (sizeMode == 2'b01) || (sizeMode == 2'b10);
  assign dblH   = (sizeMode == 2'b01) || (sizeMode == 2'b11);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsPrev <= 1'b1;
      vsPrev <= 1'b1;
      hCnt   <= '1;
      vCnt   <= '1;
    end else begin
      hsPrev <= hsAct;
      vsPrev <= vsAct;
      if (hsEdge) begin
        hCnt <= '0;
        vCnt <= vsEdge ? '0 : vCnt + 1'b1;
      end else begin
        if (hCnt != '1) hCnt <= hCnt + 1'b1;
        if (vsEdge) vCnt <= '1;
      end
    end
  end

  always_comb begin
    dx  = hCnt - HCNT_W'(hStart);
    dy  = vCnt - VCNT_W'(vStart);
    gxt = dblW ? (dx >> 1) : dx;
    gyt = dblH ? (dy >> 1) : dy;
    pos.inWin    = (hCnt >= HCNT_W'(hStart)) && (vCnt >= VCNT_W'(vStart))
                && (gxt < SPAN_X) && (gyt < SPAN_Y);
    pos.cellCol  = COL_W'(gxt / GW);
    pos.glyphX   = GX_W'(gxt % GW);
    pos.cellRow  = ROW_W'(gyt / GH);
    pos.glyphY   = GY_W'(gyt % GH);
    pos.rowStart = pos.inWin && (dx == '0) && (pos.glyphY == '0) && !(dblH && dy[0]);
  end
endmodule

// File: rtl/osd_datapath.sv
module osd_datapath
  import osd_pkg::*;
#(
  parameter int ROWS = 10,
  parameter int COLS = 24,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    vramWe,
  input  logic [ADDR_W-1:0]       vramAddr,
  input  logic [WORD_W-1:0]       vramWdata,
  input  osd_pos_t                pos,
  input  logic [COLOR_W-1:0]      rowFg,
  input  logic [COLOR_W-1:0]      rowBg,
  input  logic [NPAL*COLOR_W-1:0] paletteFlat,
  input  logic                    fringeEn,
  input  logic [COLOR_W-1:0]      fringeColor,
  output logic [COLOR_W-1:0]      rgbOut,
  output logic                    overlay,
  output logic                    rowIrq
);
  localparam int CELLS = ROWS * COLS;

  logic [WORD_W-1:0]  vram [CELLS];
  logic [WORD_W-1:0]  word;
  logic [ADDR_W-1:0]  rdAddr;
  logic [CODE_W-1:0]  code;
  logic [2:0]         colorIdx;
  logic [COLOR_W-1:0] fgTab [NPAL+1];
  logic [COLOR_W-1:0] fg;
  logic               lit, nbr;
  int                 gx, gy;

  always_ff @(posedge clk) begin
    if (vramWe && int'(vramAddr) < CELLS) vram[vramAddr] <= vramWdata;
  end

  assign rdAddr   = ADDR_W'(pos.cellRow) * ADDR_W'(COLS) + ADDR_W'(pos.cellCol);
  assign word     = (int'(rdAddr) < CELLS) ? vram[rdAddr] : '0;
  assign code     = {word[11], word[7:0]};
  assign colorIdx = word[10:8];

  assign fgTab[0] = rowFg;
  for (genvar k = 1; k <= NPAL; k++) begin : g_pal
    assign fgTab[k] = paletteFlat[COLOR_W*(k-1) +: COLOR_W];
  end
  assign fg = fgTab[colorIdx];

  assign gx  = int'(pos.glyphX);
  assign gy  = int'(pos.glyphY);
  assign lit = glyph_bit(code, gx, gy);
  assign nbr = glyph_bit(code, gx - 1, gy) | glyph_bit(code, gx + 1, gy)
             | glyph_bit(code, gx, gy - 1) | glyph_bit(code, gx, gy + 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rgbOut  <= '0;
      overlay <= 1'b0;
      rowIrq  <= 1'b0;
    end else begin
      rowIrq <= pos.rowStart;
      if (!pos.inWin) begin
        rgbOut <= '0; overlay <= 1'b0;
      end else if (lit) begin
        rgbOut <= fg; overlay <= 1'b1;
      end else if (fringeEn && nbr) begin
        rgbOut <= fringeColor; overlay <= 1'b1;
      end else if (fg == rowBg) begin
        rgbOut <= '0; overlay <= 1'b0;
      end else begin
        rgbOut <= rowBg; overlay <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/osd_top.sv
module osd_top
  import osd_pkg::*;
#(
  parameter int ROWS = 10,
  parameter int COLS = 24,
  parameter int HCNT_W = 11,
  parameter int VCNT_W = 10,
  parameter int POS_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hsyncIn,
  input  logic                    vsyncIn,
  input  logic                    syncPol,
  input  logic [POS_W-1:0]        vStart,
  input  logic [POS_W-1:0]        hStart,
  input  logic [1:0]              sizeMode,
  input  logic                    fringeEn,
  input  logic [COLOR_W-1:0]      fringeColor,
  input  logic [COLOR_W-1:0]      rowFg,
  input  logic [COLOR_W-1:0]      rowBg,
  input  logic [NPAL*COLOR_W-1:0] paletteFlat,
  input  logic                    vramWe,
  input  logic [ADDR_W-1:0]       vramAddr,
  input  logic [WORD_W-1:0]       vramWdata,
  output logic [COLOR_W-1:0]      osdRgb,
  output logic                    osdOverlay,
  output logic                    rowIrq
);
  osd_pos_t posBus;

  osd_ctrl #(.ROWS(ROWS), .COLS(COLS), .HCNT_W(HCNT_W), .VCNT_W(VCNT_W), .POS_W(POS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .syncPol(syncPol),
    .vStart(vStart), .hStart(hStart), .sizeMode(sizeMode), .pos(posBus)
  );

  osd_datapath #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .vramWe(vramWe), .vramAddr(vramAddr), .vramWdata(vramWdata),
    .pos(posBus), .rowFg(rowFg), .rowBg(rowBg), .paletteFlat(paletteFlat),
    .fringeEn(fringeEn), .fringeColor(fringeColor),
    .rgbOut(osdRgb), .overlay(osdOverlay), .rowIrq(rowIrq)
  );
endmodule

// File: rtl/osd_checker.sv
module osd_checker
  import osd_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input osd_pos_t           pos,
  input logic               overlay,
  input logic [COLOR_W-1:0] rgb,
  input logic               rowIrq
);
  assert_blank_rgb_R8: assert property (@(posedge clk) disable iff (!rstN)
    !overlay |-> rgb == '0);

  assert_outside_off_R12: assert property (@(posedge clk) disable iff (!rstN)
    !pos.inWin |=> !overlay);

  assert_irq_follows_row_R11: assert property (@(posedge clk) disable iff (!rstN)
    pos.rowStart |=> rowIrq);

  assert_irq_only_row_R11: assert property (@(posedge clk) disable iff (!rstN)
    !pos.rowStart |=> !rowIrq);

  assert_glyph_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    pos.inWin |-> (pos.glyphX < GX_W'(GLYPH_W)) && (pos.glyphY < GY_W'(GLYPH_H)));
endmodule

bind osd_top osd_checker u_chk (
  .clk(clk), .rstN(rstN), .pos(posBus), .overlay(osdOverlay), .rgb(osdRgb), .rowIrq(rowIrq)
);

// File: tb/sim_osd_top.sv
module sim_osd_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hs = 1'b0, vs = 1'b0, pol = 1'b1;
  logic [7:0] vStartR = 8'd2, hStartR = 8'd5;
  logic [1:0] mode = 2'b00;
  logic fringe = 1'b0;
  logic [5:0] fringeC = 6'h2A, fgR = 6'h3F, bgR = 6'h05;
  logic [41:0] pal;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [11:0] wdata = '0;
  logic [5:0] rgb;
  logic ovl, irq;

  int compared = 0, mismatched = 0, posCount = 0;
  bit finished = 0;
  logic [11:0] shadow [240];
  bit chkMask [256];

  typedef struct { int cyc; logic [5:0] rgb; bit ovl; bit irq; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) posCount <= posCount + 1;

  osd_top u0 (
    .clk(clk), .rstN(rstN), .hsyncIn(hs), .vsyncIn(vs), .syncPol(pol),
    .vStart(vStartR), .hStart(hStartR), .sizeMode(mode), .fringeEn(fringe),
    .fringeColor(fringeC), .rowFg(fgR), .rowBg(bgR), .paletteFlat(pal),
    .vramWe(we), .vramAddr(addr), .vramWdata(wdata),
    .osdRgb(rgb), .osdOverlay(ovl), .rowIrq(irq)
  );

  function automatic bit gl(int c, int x, int y);
    if (x < 0 || x > 13 || y < 0 || y > 17) return 0;
    return ((x + y + c) % 5) == 0;
  endfunction

  // expected pixel from the requirements (R3..R12)
  function automatic void model(input int line, input int p,
                                output logic [5:0] c, output bit o, output bit ir);
    int sx, sy, dx, dy, gxt, gyt, col, row, x, y, code, idx;
    logic [11:0] w;
    logic [5:0] fg;
    sx = (mode == 2'b01 || mode == 2'b10) ? 2 : 1;
    sy = (mode == 2'b01 || mode == 2'b11) ? 2 : 1;
    dx = p - int'(hStartR);
    dy = line - int'(vStartR);
    c = 6'h00; o = 0; ir = 0;
    if (dx < 0 || dy < 0 || dx >= 24*14*sx || dy >= 10*18*sy) return;
    gxt = dx / sx; gyt = dy / sy;
    col = gxt / 14; x = gxt % 14;
    row = gyt / 18; y = gyt % 18;
    ir = (dx == 0) && (dy % (18*sy) == 0);
    w = shadow[row*24 + col];
    code = int'({w[11], w[7:0]});
    idx = int'(w[10:8]);
    fg = (idx == 0) ? fgR : pal[6*(idx-1) +: 6];
    if (gl(code, x, y)) begin c = fg; o = 1; end
    else if (fringe && (gl(code,x-1,y) || gl(code,x+1,y) || gl(code,x,y-1) || gl(code,x,y+1))) begin
      c = fringeC; o = 1;
    end else if (fg == bgR) begin c = 6'h00; o = 0; end
    else begin c = bgR; o = 1; end
  endfunction

  // monitor: pops the scoreboard when the target cycle is reached
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= posCount) begin
      exp_t e;
      e = q.pop_front();
      compared++;
      if (rgb !== e.rgb || ovl !== e.ovl || irq !== e.irq) begin
        mismatched++;
        $display("FAIL %s cyc %0d: rgb=%h ovl=%b irq=%b expected rgb=%h ovl=%b irq=%b",
                 e.tag, e.cyc, rgb, ovl, irq, e.rgb, e.ovl, e.irq);
      end
    end
  end

  task automatic wr(input int a, input logic [11:0] d);
    we = 1; addr = 8'(a); wdata = d; shadow[a] = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic hsPulse(output int cE);
    hs = pol; @(negedge clk); hs = ~pol; cE = posCount;
  endtask

  task automatic vsPulse();
    vs = pol; @(negedge clk); vs = ~pol;
  endtask

  task automatic clearMask();
    for (int i = 0; i < 256; i++) chkMask[i] = 0;
  endtask

  task automatic frame(input int nLines, input int checkLen, input string tag);
    int cE;
    vsPulse();
    @(negedge clk);
    for (int l = 0; l < nLines; l++) begin
      hsPulse(cE);
      if (chkMask[l]) begin
        for (int p = 0; p < checkLen; p++) begin
          exp_t e;
          model(l, p, e.rgb, e.ovl, e.irq);
          e.cyc = cE + 1 + p;
          e.tag = tag;
          q.push_back(e);
        end
        repeat (checkLen + 1) @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
    clearMask();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 7; k++) pal[6*k +: 6] = 6'(k*9 + 1);
    hs = ~pol; vs = ~pol;
    clearMask();
    repeat (3) @(negedge clk);
    // R1: reset state
    compared++;
    if (rgb !== 6'h00 || ovl !== 1'b0 || irq !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 in reset: rgb=%h ovl=%b irq=%b expected 00 0 0", rgb, ovl, irq);
    end
    rstN = 1;
    repeat (2) @(negedge clk);
    compared++;
    if (rgb !== 6'h00 || ovl !== 1'b0 || irq !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 after reset: rgb=%h ovl=%b irq=%b expected 00 0 0", rgb, ovl, irq);
    end
    // R4 R5: fill the video RAM
    for (int i = 0; i < 240; i++) wr(i, 12'((i*173 + 5) % 4096));
    wr(0, 12'h004);
    // R3 R6 R7 R12: normal size, grid edges, last row and the line below the grid
    chkMask[2] = 1; chkMask[3] = 1; chkMask[7] = 1; chkMask[20] = 1;
    chkMask[181] = 1; chkMask[182] = 1;
    frame(183, 345, "R3 R6 R7 R12 normal");
    // R10 R11: fringe and row interrupt on the same first pixel
    fringe = 1;
    chkMask[2] = 1; chkMask[4] = 1; chkMask[20] = 1;
    frame(21, 70, "R10 R11 fringe");
    fringe = 0;
    // R8: equal foreground and background
    fgR = 6'h11; bgR = 6'h11;
    chkMask[2] = 1; chkMask[3] = 1;
    frame(4, 345, "R8 transparent");
    fgR = 6'h3F; bgR = 6'h05;
    // R4: rewrite a cell and see it
    wr(1, 12'h905);
    wr(24, 12'hA17);
    // R9: double size both ways
    mode = 2'b01; vStartR = 8'd1; hStartR = 8'd3;
    chkMask[1] = 1; chkMask[2] = 1; chkMask[3] = 1; chkMask[37] = 1;
    frame(38, 100, "R9 R4 double");
    // R9: double width
    mode = 2'b10;
    chkMask[1] = 1; chkMask[2] = 1; chkMask[19] = 1;
    frame(20, 100, "R9 wide");
    // R9: double height
    mode = 2'b11;
    chkMask[1] = 1; chkMask[2] = 1; chkMask[37] = 1;
    frame(38, 70, "R9 tall");
    // R2: active-low syncs
    mode = 2'b00; vStartR = 8'd2; hStartR = 8'd5;
    @(negedge clk);
    pol = 0; hs = 1; vs = 1;
    @(negedge clk);
    chkMask[2] = 1; chkMask[3] = 1; chkMask[21] = 1;
    frame(22, 70, "R2 low polarity");
    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule